// File: doc/BRIEF.md
# Protection-Unit Region Configuration Register Bank

This block keeps the configuration state of a memory protection unit that has a parameterised number of regions (up to 16). Software reaches it over a simple word-wide register bus. A window register chooses which region the base and attribute registers refer to. Both the base register and the attribute register can be reached at several alias offsets that all do the same thing. A base write can also carry its own region number. In that case it moves the window register as a side effect. Region numbers that point past the last region are dropped quietly, with no error response.

Every stored word is always visible on wide output buses: the base of each region, its size/enable half-word and its access-control half-word, plus the control bits. A lookup block uses these buses to check addresses against all regions in parallel.

The bus has no back-pressure. A request is accepted in the cycle it is presented, and there is no ready signal. A read answers exactly one cycle later on `rsp_valid`/`rsp_rdata`. A write gives no response. The consumer of the response cannot stall the bank.

Top module: `mpu_regbank`

## Requirements
- R1: Reset clears the following to zero: the control bits, the window register, and every region's base, size/enable and access-control words.
- R2: A read request is answered by `rsp_valid` high in the next cycle, with the read data on `rsp_rdata`. In any cycle after a write or an idle cycle, `rsp_valid` is low and `rsp_rdata` is zero.
- R3: A write to the window register at offset 0xD98 with a value of NUM_REGIONS or more is ignored, so the window keeps its old value. A smaller value is stored, and reading 0xD98 returns it zero-extended.
- R4: Offsets 0xD9C, 0xDA4, 0xDAC and 0xDB4 all reach the base register of the selected region. Offsets 0xDA0, 0xDA8, 0xDB0 and 0xDB8 all reach its attribute register. All offsets in each group behave identically for reads and writes.
- R5: A base write with bit 4 clear stores data bits 31:5 into the selected region. A base read returns the stored bits in 31:5 and zero in bits 4:0.
- R6: A base write with bit 4 set takes its region number from data bits 3:0. If that number is below NUM_REGIONS, the window register is set to it and that region's base is written. Otherwise the whole write is ignored, and both the window register and every base stay unchanged.
- R7: An attribute write puts data bits 15:0 into the selected region's size/enable word and bits 31:16 into its access-control word. A read returns both halves in the same positions.
- R8: A write to 0xD94 stores data bits 2:0 as the control bits, which drive `ctrl_o`. A read of 0xD94 returns them with all upper bits zero.
- R9: A read of any other offset, including ones that are not word-aligned, returns zero. A write to such an offset changes no state.
- R10: Region r's words appear at bits [r*27 +: 27] of `base_o`, [r*16 +: 16] of `szen_o` and [r*16 +: 16] of `acc_o`. Each reflects the stored value from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after a read) |
| rsp_rdata | output | 32 | Read data, zero when not valid |
| ctrl_o | output | CTRL_W | Control bits |
| base_o | output | NUM_REGIONS*27 | Per-region base bits 31:5 |
| szen_o | output | NUM_REGIONS*16 | Per-region size/enable words |
| acc_o | output | NUM_REGIONS*16 | Per-region access-control words |

## Verification
The bench writes through one alias and reads back through every other alias of the same register. A decode that mapped only the primary offset would then return zero, or would hit the wrong register. It writes window values equal to and far above the region count, and flag-carrying base writes whose embedded number is out of range. A design that stored or truncated such values would move the window and corrupt a base, and the bench would see this on the per-region output buses. Writes to unmapped and misaligned offsets are followed by a full comparison of all outputs. A second reset taken in the middle of the run confirms that every region word is cleared, not just the control bits.

// File: rtl/mpu_regbank_pkg.sv
`timescale 1ns/1ps
package mpu_regbank_pkg;
  localparam int ADDR_W       = 12;
  localparam int DATA_W       = 32;
  localparam int RNUM_W       = 4;   // embedded region number width
  localparam int FLAG_BIT     = 4;   // region-valid flag in base data
  localparam int BASE_LO      = 5;   // lowest stored base bit
  localparam int BASE_W       = DATA_W - BASE_LO;
  localparam int HALF_W       = 16;
  localparam int ALIAS_N      = 4;
  localparam int ALIAS_STRIDE = 8;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'hD94;
  localparam logic [ADDR_W-1:0] OFS_SEL   = 12'hD98;
  localparam logic [ADDR_W-1:0] OFS_BASE0 = 12'hD9C;
  localparam logic [ADDR_W-1:0] OFS_ATTR0 = 12'hDA0;

  typedef enum logic [2:0] {
    K_NONE = 3'd0,
    K_CTRL = 3'd1,
    K_SEL  = 3'd2,
    K_BASE = 3'd3,
    K_ATTR = 3'd4
  } reg_kind_e;
endpackage

// File: rtl/mpu_addr_decode.sv
`timescale 1ns/1ps
module mpu_addr_decode
  import mpu_regbank_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind
);
  logic [ALIAS_N-1:0] hit_base;
  logic [ALIAS_N-1:0] hit_attr;

  for (genvar k = 0; k < ALIAS_N; k++) begin : g_alias
    assign hit_base[k] = (addr == OFS_BASE0 + ADDR_W'(k * ALIAS_STRIDE));
    assign hit_attr[k] = (addr == OFS_ATTR0 + ADDR_W'(k * ALIAS_STRIDE));
  end

  always_comb begin
    kind = K_NONE;
    if (addr == OFS_CTRL)   kind = K_CTRL;
    else if (addr == OFS_SEL) kind = K_SEL;
    else if (|hit_base)     kind = K_BASE;
    else if (|hit_attr)     kind = K_ATTR;
  end
endmodule

// File: rtl/mpu_region_sel.sv
`timescale 1ns/1ps
module mpu_region_sel
  import mpu_regbank_pkg::*;
#(
  parameter int NUM_REGIONS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel,
  input  logic              wr_base,
  input  logic [DATA_W-1:0] wdata,
  output logic [RNUM_W-1:0] sel,
  output logic              sel_ok,
  output logic              base_commit,
  output logic [RNUM_W-1:0] base_idx
);
  localparam logic [RNUM_W:0]   N_NARROW = (RNUM_W+1)'(NUM_REGIONS);
  localparam logic [DATA_W-1:0] N_WIDE   = DATA_W'(NUM_REGIONS);

  logic              flag;
  logic [RNUM_W-1:0] emb;
  logic              emb_ok;
  logic              val_ok;

  assign flag   = wdata[FLAG_BIT];
  assign emb    = wdata[RNUM_W-1:0];
  assign emb_ok = ({1'b0, emb} < N_NARROW);
  assign val_ok = (wdata < N_WIDE);
  assign sel_ok = ({1'b0, sel} < N_NARROW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel <= '0;
    end else if (wr_sel && val_ok) begin
      sel <= wdata[RNUM_W-1:0];
    end else if (wr_base && flag && emb_ok) begin
      sel <= emb;
    end
  end

  assign base_idx    = (wr_base && flag) ? emb : sel;
  assign base_commit = wr_base && (flag ? emb_ok : sel_ok);

  assert_sel_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, sel} < N_NARROW);

  assert_sel_oor_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && wdata >= N_WIDE) |=> $stable(sel));

  assert_flag_oor_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_base && wdata[FLAG_BIT] && {1'b0, wdata[RNUM_W-1:0]} >= N_NARROW)
      |=> $stable(sel));

  assert_flag_moves_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_base && wdata[FLAG_BIT] && {1'b0, wdata[RNUM_W-1:0]} < N_NARROW)
      |=> (sel == $past(wdata[RNUM_W-1:0])));
endmodule

// File: rtl/mpu_region_store.sv
`timescale 1ns/1ps
module mpu_region_store
  import mpu_regbank_pkg::*;
#(
  parameter int NUM_REGIONS = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          base_we,
  input  logic [RNUM_W-1:0]             base_idx,
  input  logic [BASE_W-1:0]             base_val,
  input  logic                          attr_we,
  input  logic [RNUM_W-1:0]             attr_idx,
  input  logic [DATA_W-1:0]             attr_val,
  input  logic [RNUM_W-1:0]             rd_idx,
  output logic [NUM_REGIONS*BASE_W-1:0] base_o,
  output logic [NUM_REGIONS*HALF_W-1:0] szen_o,
  output logic [NUM_REGIONS*HALF_W-1:0] acc_o,
  output logic [DATA_W-1:0]             rd_base,
  output logic [DATA_W-1:0]             rd_attr
);
  logic [BASE_W-1:0] base_q [NUM_REGIONS];
  logic [HALF_W-1:0] szen_q [NUM_REGIONS];
  logic [HALF_W-1:0] acc_q  [NUM_REGIONS];

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[r] <= '0;
        szen_q[r] <= '0;
        acc_q[r]  <= '0;
      end else begin
        if (base_we && base_idx == RNUM_W'(r)) base_q[r] <= base_val;
        if (attr_we && attr_idx == RNUM_W'(r)) begin
          szen_q[r] <= attr_val[HALF_W-1:0];
          acc_q[r]  <= attr_val[DATA_W-1:HALF_W];
        end
      end
    end
    assign base_o[r*BASE_W +: BASE_W] = base_q[r];
    assign szen_o[r*HALF_W +: HALF_W] = szen_q[r];
    assign acc_o[r*HALF_W +: HALF_W]  = acc_q[r];
  end

  // An index past the last region matches no entry and reads zero.
  always_comb begin
    rd_base = '0;
    rd_attr = '0;
    for (int r = 0; r < NUM_REGIONS; r++) begin
      if (rd_idx == RNUM_W'(r)) begin
        rd_base = {base_q[r], {BASE_LO{1'b0}}};
        rd_attr = {acc_q[r], szen_q[r]};
      end
    end
  end
endmodule

// File: rtl/mpu_regbank.sv
`timescale 1ns/1ps
module mpu_regbank
  import mpu_regbank_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int CTRL_W      = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic                          req_write,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [DATA_W-1:0]             req_wdata,
  output logic                          rsp_valid,
  output logic [DATA_W-1:0]             rsp_rdata,
  output logic [CTRL_W-1:0]             ctrl_o,
  output logic [NUM_REGIONS*BASE_W-1:0] base_o,
  output logic [NUM_REGIONS*HALF_W-1:0] szen_o,
  output logic [NUM_REGIONS*HALF_W-1:0] acc_o
);
  reg_kind_e         kind;
  logic              wr;
  logic              rd;
  logic [CTRL_W-1:0] ctrl_q;
  logic [RNUM_W-1:0] sel;
  logic              sel_ok;
  logic              base_commit;
  logic [RNUM_W-1:0] base_idx;
  logic [DATA_W-1:0] rd_base;
  logic [DATA_W-1:0] rd_attr;
  logic [DATA_W-1:0] rd_mux;

  assign wr = req_valid && req_write;
  assign rd = req_valid && !req_write;

  mpu_addr_decode u_decode (
    .addr (req_addr),
    .kind (kind)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    ctrl_q <= '0;
    else if (wr && kind == K_CTRL) ctrl_q <= req_wdata[CTRL_W-1:0];
  end
  assign ctrl_o = ctrl_q;

  mpu_region_sel #(.NUM_REGIONS(NUM_REGIONS)) u_sel (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_sel      (wr && kind == K_SEL),
    .wr_base     (wr && kind == K_BASE),
    .wdata       (req_wdata),
    .sel         (sel),
    .sel_ok      (sel_ok),
    .base_commit (base_commit),
    .base_idx    (base_idx)
  );

  mpu_region_store #(.NUM_REGIONS(NUM_REGIONS)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .base_we  (base_commit),
    .base_idx (base_idx),
    .base_val (req_wdata[DATA_W-1:BASE_LO]),
    .attr_we  (wr && kind == K_ATTR && sel_ok),
    .attr_idx (sel),
    .attr_val (req_wdata),
    .rd_idx   (sel),
    .base_o   (base_o),
    .szen_o   (szen_o),
    .acc_o    (acc_o),
    .rd_base  (rd_base),
    .rd_attr  (rd_attr)
  );

  always_comb begin
    unique case (kind)
      K_CTRL:  rd_mux = DATA_W'(ctrl_q);
      K_SEL:   rd_mux = DATA_W'(sel);
      K_BASE:  rd_mux = rd_base;
      K_ATTR:  rd_mux = rd_attr;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      rsp_rdata <= rd ? rd_mux : '0;
    end
  end

  assert_read_answered_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> (!rsp_valid && rsp_rdata == '0));

  assert_unmapped_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && kind == K_NONE) |=> (rsp_rdata == '0));

  assert_ctrl_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == OFS_CTRL)
      |=> (ctrl_o == $past(req_wdata[CTRL_W-1:0])));
endmodule

// File: tb/mpu_regbank_test.sv
`timescale 1ns/1ps
module mpu_regbank_test;
  localparam int N  = 8;
  localparam int CW = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [11:0]       req_addr = '0;
  logic [31:0]       req_wdata = '0;
  logic              rsp_valid;
  logic [31:0]       rsp_rdata;
  logic [CW-1:0]     ctrl_o;
  logic [N*27-1:0]   base_o;
  logic [N*16-1:0]   szen_o;
  logic [N*16-1:0]   acc_o;

  mpu_regbank #(.NUM_REGIONS(N), .CTRL_W(CW)) uut (
    .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_wdata,
    .rsp_valid, .rsp_rdata, .ctrl_o, .base_o, .szen_o, .acc_o
  );

  always #4 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  // behavioural reference state
  int unsigned m_base [N];
  int unsigned m_attr [N];
  int unsigned m_sel;
  int unsigned m_ctrl;
  bit          e_valid;
  int unsigned e_rdata;

  task automatic check(bit ok, string req, int unsigned act, int unsigned exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic int kind_of(logic [11:0] a);
    int off;
    if (a == 12'hD94) return 1;
    if (a == 12'hD98) return 2;
    if (a >= 12'hD9C && a <= 12'hDB8) begin
      off = int'(a) - 'hD9C;
      if (off % 8 == 0) return 3;
      if (off % 8 == 4) return 4;
    end
    return 0;
  endfunction

  function automatic int unsigned model_read(logic [11:0] a);
    case (kind_of(a))
      1: return m_ctrl;
      2: return m_sel;
      3: return m_base[m_sel];
      4: return m_attr[m_sel];
      default: return 0;
    endcase
  endfunction

  task automatic model_write(logic [11:0] a, logic [31:0] d);
    case (kind_of(a))
      1: m_ctrl = d & 32'h7;
      2: if (d < N) m_sel = d;
      3: begin
        if (d[4]) begin
          if (d[3:0] < N) begin
            m_sel = d[3:0];
            m_base[m_sel] = d & 32'hFFFF_FFE0;
          end
        end else begin
          m_base[m_sel] = d & 32'hFFFF_FFE0;
        end
      end
      4: m_attr[m_sel] = d;
      default: ;
    endcase
  endtask

  task automatic model_reset();
    for (int r = 0; r < N; r++) begin
      m_base[r] = 0;
      m_attr[r] = 0;
    end
    m_sel = 0;
    m_ctrl = 0;
    e_valid = 0;
    e_rdata = 0;
  endtask

  task automatic compare_all(string tag);
    check(rsp_valid == e_valid, "R2", 32'(rsp_valid), 32'(e_valid));
    check(rsp_rdata == e_rdata, tag, rsp_rdata, e_rdata);
    check(32'(ctrl_o) == m_ctrl, "R8", 32'(ctrl_o), m_ctrl);
    for (int r = 0; r < N; r++) begin
      check({base_o[r*27 +: 27], 5'b0} == m_base[r], "R10 base",
            {base_o[r*27 +: 27], 5'b0}, m_base[r]);
      check({acc_o[r*16 +: 16], szen_o[r*16 +: 16]} == m_attr[r], "R10 attr",
            {acc_o[r*16 +: 16], szen_o[r*16 +: 16]}, m_attr[r]);
    end
  endtask

  // one bus cycle; compare everything after the edge
  task automatic step(bit w, logic [11:0] a, logic [31:0] d, string tag);
    req_valid = 1'b1;
    req_write = w;
    req_addr  = a;
    req_wdata = d;
    @(posedge clk);
    e_valid = !w;
    e_rdata = w ? 0 : model_read(a);
    if (w) model_write(a, d);
    @(negedge clk);
    req_valid = 1'b0;
    compare_all(tag);
  endtask

  task automatic idle(string tag);
    @(posedge clk);
    e_valid = 0;
    e_rdata = 0;
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    compare_all("R1");
    rst_n = 1'b1;
    idle("R1");
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    @(negedge clk);
    do_reset();

    // R1: reset values via the bus
    step(0, 12'hD98, 0, "R1 sel");
    step(0, 12'hD9C, 0, "R1 base");
    step(0, 12'hDA0, 0, "R1 attr");
    step(0, 12'hD94, 0, "R1 ctrl");

    // R8: control bits
    step(1, 12'hD94, 32'hFFFF_FFFF, "R8");
    step(0, 12'hD94, 0, "R8 read");
    step(1, 12'hD94, 32'h0000_0005, "R8");
    step(0, 12'hD94, 0, "R8 read");

    // R5 / R4: base write and alias reads
    step(1, 12'hD98, 3, "R3");
    step(1, 12'hD9C, 32'h1234_566F, "R5");
    step(0, 12'hD9C, 0, "R4 R5 base alias0");
    step(0, 12'hDA4, 0, "R4 base alias1");
    step(0, 12'hDAC, 0, "R4 base alias2");
    step(0, 12'hDB4, 0, "R4 base alias3");
    step(1, 12'hDB4, 32'h89AB_CDE0, "R4 write alias3");
    step(0, 12'hDA4, 0, "R4 base alias1");

    // R7 / R4: attribute split and aliases
    step(1, 12'hDB0, 32'hABCD_0021, "R7");
    step(0, 12'hDA0, 0, "R4 R7 attr alias0");
    step(0, 12'hDA8, 0, "R4 attr alias1");
    step(0, 12'hDB0, 0, "R4 attr alias2");
    step(0, 12'hDB8, 0, "R4 attr alias3");
    step(1, 12'hDA8, 32'h1357_2468, "R4 write attr alias1");
    step(0, 12'hDB8, 0, "R4 attr alias3");

    // R3: out-of-range window values
    step(1, 12'hD98, N, "R3");
    step(0, 12'hD98, 0, "R3 kept at N");
    step(1, 12'hD98, 32'hFFFF_FFFF, "R3");
    step(0, 12'hD98, 0, "R3 kept at max");
    step(1, 12'hD98, 32'h0000_0013, "R3");
    step(0, 12'hD98, 0, "R3 wide value");
    step(1, 12'hD98, N - 1, "R3");
    step(0, 12'hD98, 0, "R3 last region");

    // R6: flagged base writes
    step(1, 12'hDA4, 32'h4000_0015, "R6");
    step(0, 12'hD98, 0, "R6 sel moved");
    step(0, 12'hD9C, 0, "R6 base");
    step(1, 12'hDAC, 32'h5000_0019, "R6 oor");
    step(0, 12'hD98, 0, "R6 sel kept");
    step(1, 12'hD9C, 32'h6000_001F, "R6 oor 15");
    step(0, 12'hD9C, 0, "R6 base kept");
    step(1, 12'hD9C, 32'h7000_0010, "R6 region 0");
    step(0, 12'hD98, 0, "R6 sel zero");

    // R9: unmapped and misaligned offsets
    step(0, 12'hD90, 0, "R9 read");
    step(0, 12'hDBC, 0, "R9 read");
    step(0, 12'hD9D, 0, "R9 misaligned read");
    step(0, 12'h000, 0, "R9 read");
    step(1, 12'hDBC, 32'hFFFF_FFFF, "R9 write");
    step(1, 12'hD9E, 32'hFFFF_FFFF, "R9 write");
    step(1, 12'hD95, 32'hFFFF_FFFF, "R9 write");
    step(0, 12'hD98, 0, "R9 sel untouched");
    step(0, 12'hD94, 0, "R9 ctrl untouched");

    // R10: fill every region, back-to-back
    for (int r = 0; r < N; r++) begin
      step(1, 12'hD98, r, "R10");
      step(1, 12'hD9C, 32'h0100_0000 * (r + 1) + 32'h0000_0E0, "R10");
      step(1, 12'hDA0, 32'h00A5_0000 + 32'h0000_1111 * r, "R10");
    end
    for (int r = N - 1; r >= 0; r--) begin
      step(1, 12'hD9C, 32'h10 | r, "R6 flag select");
      step(0, 12'hDA8, 0, "R2 R7 back-to-back");
      step(0, 12'hDB4, 0, "R2 R5 back-to-back");
    end
    idle("R2");

    // R1: reset in mid-run
    do_reset();
    step(0, 12'hD9C, 0, "R1 base after reset");
    step(0, 12'hD98, 0, "R1 sel after reset");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule